// File: doc/BRIEF.md
# Accumulator and Link-Bit Logic Unit

This block is the working register of a small accumulator machine: a 16-bit accumulator, the per-bit arithmetic and logic network in front of it, and a single link flip-flop that catches the add carry and takes part in both rotations. A control sequencer outside the block raises one operation select in a cycle. The accumulator and the link take their new values on the next rising clock edge. The operand comes from a data register input and from an 8-bit character input.

Seven of the operations produce a value through the logic network and write it through the register's load input: AND, add, data transfer, character transfer, complement, rotate right and rotate left. Increment and clear use the register's own count and clear inputs. Two more selects act only on the link bit, one clearing it and one inverting it. The accumulator's zero and sign conditions are brought out so that the outside sequencer can use them in its conditional skip decisions.

Top module: `acc_link_unit`

## Requirements
- R1: While rst_n is low, and right after reset, acc is 0 and link is 0.
- R2: sel_and loads acc with acc & dr_in. The link does not change.
- R3: sel_add loads acc with the low 16 bits of acc + dr_in and loads link with the carry out of bit 15.
- R4: sel_xfer_dr loads acc with dr_in. The link does not change.
- R5: sel_xfer_chr loads acc[7:0] from chr_in and clears acc[15:8]. The link does not change.
- R6: sel_cmp replaces acc with its bitwise complement. The link does not change.
- R7: sel_rotr loads acc with {link, acc[15:1]} and loads link with the old acc[0].
- R8: sel_rotl loads acc with {acc[14:0], link} and loads link with the old acc[15].
- R9: sel_inc adds one to acc modulo 2^16, so 16'hFFFF becomes 0. The link does not change.
- R10: sel_clr sets acc to 0. The link does not change.
- R11: sel_lclr clears link and sel_lcmp inverts link. Neither changes acc.
- R12: At most one select is high in a cycle. With none high, acc and link hold, whatever dr_in and chr_in do.
- R13: acc_zero is 1 exactly when acc is 0, and acc_neg equals acc[15]. Both follow acc in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dr_in | input | 16 | Operand from the data register |
| chr_in | input | 8 | Character from the input register |
| sel_and | input | 1 | AND the operand into acc |
| sel_add | input | 1 | Add the operand, carry to link |
| sel_xfer_dr | input | 1 | Copy the operand into acc |
| sel_xfer_chr | input | 1 | Copy the character into acc, upper bits cleared |
| sel_cmp | input | 1 | Complement acc |
| sel_rotr | input | 1 | Rotate acc and link right |
| sel_rotl | input | 1 | Rotate acc and link left |
| sel_inc | input | 1 | Increment acc |
| sel_clr | input | 1 | Clear acc |
| sel_lclr | input | 1 | Clear link |
| sel_lcmp | input | 1 | Complement link |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| acc_zero | output | 1 | acc equals zero |
| acc_neg | output | 1 | Sign bit of acc |

## Verification
The rotations are the hardest part to reach from the ports, because their result depends on a link value that only an add carry, an earlier rotation or a link select can set up. The stimulus therefore places the link in a known state with the clear and complement selects before each rotation. It then chains rotations so that the bit moved out by one rotation returns through the link in the next. The add carry is covered from both sides: one sum overflows past bit 15 and one does not, and the stored link must follow the carry in both cases.

// File: rtl/acc_link_pkg.sv
package acc_link_pkg;

   // Adder built from a gate-level ripple chain or left to the synthesis operator.
   typedef enum logic [0:0] {
      ADD_RIPPLE = 1'b0,
      ADD_NATIVE = 1'b1
   } adder_kind_e;

   // Selects that write acc through the parallel-load path.
   typedef struct packed {
      logic op_and;
      logic op_add;
      logic op_xdr;
      logic op_xchr;
      logic op_cmp;
      logic op_rotr;
      logic op_rotl;
   } load_ops_t;

endpackage

// File: rtl/acc_logic_net.sv
module acc_logic_net
   import acc_link_pkg::*;
#(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned CHAR_W = 8,
   parameter adder_kind_e ADDER  = ADD_RIPPLE
) (
   input  load_ops_t         ops,
   input  logic [WIDTH-1:0]  ac_q,
   input  logic              link_q,
   input  logic [WIDTH-1:0]  dr,
   input  logic [CHAR_W-1:0] chr,
   output logic              ld,
   output logic [WIDTH-1:0]  ld_val,
   output logic              link_wr,
   output logic              link_val
);
   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] sum;
   logic             cout;

   generate
      if (ADDER == ADD_RIPPLE) begin : g_ripple
         logic [WIDTH:0] c;
         assign c[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_fa
            assign sum[i]   = ac_q[i] ^ dr[i] ^ c[i];
            assign c[i+1]   = (ac_q[i] & dr[i]) | (c[i] & (ac_q[i] ^ dr[i]));
         end
         assign cout = c[WIDTH];
      end else begin : g_native
         assign {cout, sum} = {1'b0, ac_q} + {1'b0, dr};
      end
   endgenerate

   // Per-bit AND-OR select network, one slice for each accumulator bit.
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic rr_bit, rl_bit, ch_bit;
         if (i == MSB) begin : g_top
            assign rr_bit = link_q;
         end else begin : g_mid_r
            assign rr_bit = ac_q[i+1];
         end
         if (i == 0) begin : g_bot
            assign rl_bit = link_q;
         end else begin : g_mid_l
            assign rl_bit = ac_q[i-1];
         end
         if (i < CHAR_W) begin : g_chr
            assign ch_bit = chr[i];
         end else begin : g_nochr
            assign ch_bit = 1'b0;
         end
         assign ld_val[i] = (ops.op_and  & ac_q[i] & dr[i])
                          | (ops.op_add  & sum[i])
                          | (ops.op_xdr  & dr[i])
                          | (ops.op_xchr & ch_bit)
                          | (ops.op_cmp  & ~ac_q[i])
                          | (ops.op_rotr & rr_bit)
                          | (ops.op_rotl & rl_bit);
      end
   endgenerate

   assign ld       = |ops;
   assign link_wr  = ops.op_add | ops.op_rotr | ops.op_rotl;
   assign link_val = (ops.op_add  & cout)
                   | (ops.op_rotr & ac_q[0])
                   | (ops.op_rotl & ac_q[MSB]);
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             inr,
   input  logic             clr,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (ld)   q <= d;
      else if (inr)  q <= q + ONE;
   end
endmodule

// File: rtl/link_ff.sv
module link_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic d,
   input  logic clr,
   input  logic cmp,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (wr)  q <= d;
      else if (clr) q <= 1'b0;
      else if (cmp) q <= ~q;
   end
endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
   import acc_link_pkg::*;
#(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned CHAR_W = 8,
   parameter adder_kind_e ADDER  = ADD_RIPPLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  dr_in,
   input  logic [CHAR_W-1:0] chr_in,
   input  logic              sel_and,
   input  logic              sel_add,
   input  logic              sel_xfer_dr,
   input  logic              sel_xfer_chr,
   input  logic              sel_cmp,
   input  logic              sel_rotr,
   input  logic              sel_rotl,
   input  logic              sel_inc,
   input  logic              sel_clr,
   input  logic              sel_lclr,
   input  logic              sel_lcmp,
   output logic [WIDTH-1:0]  acc,
   output logic              link,
   output logic              acc_zero,
   output logic              acc_neg
);
   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_link_unit: WIDTH must be at least 2");
      end
      if (CHAR_W < 1 || CHAR_W > WIDTH) begin : g_bad_char
         $error("acc_link_unit: CHAR_W must lie in 1..WIDTH");
      end
   endgenerate

   load_ops_t        ops;
   logic             ld, link_wr, link_val;
   logic [WIDTH-1:0] ld_val;

   assign ops = '{op_and:  sel_and,      op_add:  sel_add,
                  op_xdr:  sel_xfer_dr,  op_xchr: sel_xfer_chr,
                  op_cmp:  sel_cmp,      op_rotr: sel_rotr,
                  op_rotl: sel_rotl};

   acc_logic_net #(.WIDTH(WIDTH), .CHAR_W(CHAR_W), .ADDER(ADDER)) u_net (
      .ops      (ops),
      .ac_q     (acc),
      .link_q   (link),
      .dr       (dr_in),
      .chr      (chr_in),
      .ld       (ld),
      .ld_val   (ld_val),
      .link_wr  (link_wr),
      .link_val (link_val)
   );

   acc_reg #(.WIDTH(WIDTH)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld),
      .inr   (sel_inc),
      .clr   (sel_clr),
      .d     (ld_val),
      .q     (acc)
   );

   link_ff u_link (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (link_wr),
      .d     (link_val),
      .clr   (sel_lclr),
      .cmp   (sel_lcmp),
      .q     (link)
   );

   assign acc_zero = ~|acc;
   assign acc_neg  = acc[MSB];
endmodule

// File: rtl/acc_link_unit_chk.sv
module acc_link_unit_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] dr_in,
   input logic [10:0]      sels,
   input logic [WIDTH-1:0] acc,
   input logic             link
);
   // sels order: and, add, xdr, xchr, cmp, rotr, rotl, inc, clr, lclr, lcmp

   // R12
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sels));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sels == '0) |=> ($stable(acc) && $stable(link)));

   // R3
   add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sels[9] |=> ({link, acc} == ({1'b0, $past(acc)} + {1'b0, $past(dr_in)})));

   // R7
   rotr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sels[5] |=> (acc == {$past(link), $past(acc[WIDTH-1:1])} && link == $past(acc[0])));

   // R8
   rotl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sels[4] |=> (acc == {$past(acc[WIDTH-2:0]), $past(link)} && link == $past(acc[WIDTH-1])));

   // R10
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sels[2] |=> (acc == '0 && $stable(link)));

   // R11
   lcmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sels[0] |=> (link != $past(link) && $stable(acc)));
endmodule

bind acc_link_unit acc_link_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .dr_in (dr_in),
   .sels  ({sel_and, sel_add, sel_xfer_dr, sel_xfer_chr, sel_cmp, sel_rotr,
            sel_rotl, sel_inc, sel_clr, sel_lclr, sel_lcmp}),
   .acc   (acc),
   .link  (link)
);

// File: tb/acc_link_unit_test.sv
module acc_link_unit_test;
   localparam int PERIOD = 10;

   localparam int K_AND = 0, K_ADD = 1, K_XDR = 2, K_XCHR = 3, K_CMP = 4,
                  K_ROTR = 5, K_ROTL = 6, K_INC = 7, K_CLR = 8, K_LCLR = 9,
                  K_LCMP = 10, K_NONE = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] dr_in = '0;
   logic [7:0]  chr_in = '0;
   logic [10:0] s = '0;
   logic [15:0] acc;
   logic        link, acc_zero, acc_neg;

   int checks = 0;
   int errors = 0;

   logic [15:0] m_ac;
   logic        m_e;

   always #(PERIOD/2) clk = ~clk;

   acc_link_unit uut (
      .clk(clk), .rst_n(rst_n), .dr_in(dr_in), .chr_in(chr_in),
      .sel_and(s[K_AND]), .sel_add(s[K_ADD]), .sel_xfer_dr(s[K_XDR]),
      .sel_xfer_chr(s[K_XCHR]), .sel_cmp(s[K_CMP]), .sel_rotr(s[K_ROTR]),
      .sel_rotl(s[K_ROTL]), .sel_inc(s[K_INC]), .sel_clr(s[K_CLR]),
      .sel_lclr(s[K_LCLR]), .sel_lcmp(s[K_LCMP]),
      .acc(acc), .link(link), .acc_zero(acc_zero), .acc_neg(acc_neg)
   );

   task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Compare acc, link and both status flags against the bench model.
   task automatic chk_state(input string req);
      chk(req, {link, acc}, {m_e, m_ac});
      chk({req, "/R13"}, {15'd0, acc_zero, acc_neg}, {15'd0, (m_ac == 16'h0), m_ac[15]});
   endtask

   // Called at a falling edge: raise one select for one rising edge.
   task automatic fire(input int k);
      s = '0;
      if (k != K_NONE) s[k] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      s = '0;
   endtask

   task automatic put(input logic [15:0] v);
      dr_in = v; fire(K_XDR); m_ac = v;
   endtask

   task automatic set_link(input logic v);
      fire(K_LCLR); m_e = 1'b0;
      if (v) begin fire(K_LCMP); m_e = 1'b1; end
   endtask

   task automatic t_reset;
      m_ac = '0; m_e = 1'b0;
      chk_state("R1 during reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1 after reset");
   endtask

   task automatic t_xfer_dr;
      dr_in = 16'h1234; fire(K_XDR); m_ac = 16'h1234;
      chk_state("R4 xfer 1234");
      dr_in = 16'hFFFF; fire(K_XDR); m_ac = 16'hFFFF;
      chk_state("R4 xfer FFFF");
   endtask

   task automatic t_and;
      set_link(1'b1);
      put(16'hF0F0);
      dr_in = 16'h3C3C; fire(K_AND); m_ac = 16'hF0F0 & 16'h3C3C;
      chk_state("R2 and");
   endtask

   task automatic t_add;
      put(16'h8001);
      dr_in = 16'h8003; fire(K_ADD); m_ac = 16'h0004; m_e = 1'b1;
      chk_state("R3 add with carry");
      put(16'h0001);
      dr_in = 16'h0002; fire(K_ADD); m_ac = 16'h0003; m_e = 1'b0;
      chk_state("R3 add no carry");
      put(16'hFFFF);
      dr_in = 16'h0001; fire(K_ADD); m_ac = 16'h0000; m_e = 1'b1;
      chk_state("R3 add wrap to zero");
   endtask

   task automatic t_chr;
      put(16'hFFFF);
      dr_in = 16'h5555; chr_in = 8'hA5; fire(K_XCHR); m_ac = 16'h00A5;
      chk_state("R5 char load clears upper");
   endtask

   task automatic t_cmp;
      put(16'h00A5);
      fire(K_CMP); m_ac = 16'hFF5A;
      chk_state("R6 complement");
   endtask

   task automatic t_rot;
      set_link(1'b1);
      put(16'h0003);
      fire(K_ROTR); m_ac = 16'h8001; m_e = 1'b1;
      chk_state("R7 rotr link in");
      fire(K_ROTR); m_ac = 16'hC000; m_e = 1'b1;
      chk_state("R7 rotr chained");
      set_link(1'b0);
      put(16'h8000);
      fire(K_ROTL); m_ac = 16'h0000; m_e = 1'b1;
      chk_state("R8 rotl msb to link");
      fire(K_ROTL); m_ac = 16'h0001; m_e = 1'b0;
      chk_state("R8 rotl link back in");
   endtask

   task automatic t_inc;
      set_link(1'b1);
      put(16'hFFFF);
      fire(K_INC); m_ac = 16'h0000;
      chk_state("R9 inc wrap");
      put(16'h7FFF);
      fire(K_INC); m_ac = 16'h8000;
      chk_state("R9 inc to sign");
   endtask

   task automatic t_clr;
      put(16'hBEEF);
      fire(K_CLR); m_ac = 16'h0000;
      chk_state("R10 clear acc");
   endtask

   task automatic t_link_ops;
      put(16'h1357);
      fire(K_LCLR); m_e = 1'b0;
      chk_state("R11 link clear");
      fire(K_LCMP); m_e = 1'b1;
      chk_state("R11 link complement set");
      fire(K_LCMP); m_e = 1'b0;
      chk_state("R11 link complement back");
   endtask

   task automatic t_hold;
      set_link(1'b1);
      put(16'h2468);
      for (int i = 0; i < 3; i++) begin
         dr_in = 16'h9999 + 16'(i); chr_in = 8'h3C + 8'(i);
         fire(K_NONE);
         chk_state("R12 idle hold");
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_xfer_dr();
      t_and();
      t_add();
      t_chr();
      t_cmp();
      t_rot();
      t_inc();
      t_clr();
      t_link_ops();
      t_hold();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule